// File: doc/BRIEF.md
# Submission Queue Shadow-Tail Fetcher

This block manages command fetch for one submission queue of a storage controller whose host can keep doorbell values in ordinary host memory. A doorbell register write schedules a processing pass a fixed number of cycles later. When a shadow tail address is configured, the pass takes the tail from host memory through a small DMA port and ignores the tail carried by the register write. With no shadow address configured, the register value is the tail.

During a pass the block dispatches one command fetch address at a time, computed from the queue base and the head index. It goes on while the queue holds entries and a request slot is free. In shadow mode, after every dispatched command it publishes the tail it currently holds to a host event-index word and then reads the shadow tail again. The host can therefore append work during a pass without ringing the register doorbell. Head, tail and the free-slot count are visible on output ports. Decoding commands and posting completions are handled elsewhere.

Top module: `sq_shadow_fetch`

## Requirements
- R1: After reset, head and tail are 0, the free-slot count equals SLOTS, busy is low, and no DMA or dispatch request is raised.
- R2: A doorbell write starts a processing pass no sooner than DELAY_CYC cycles later, and the pass starts within DELAY_CYC+3 cycles. A doorbell during the wait restarts the wait.
- R3: A pass dispatches commands while head differs from tail and the free-slot count is nonzero. It ends once either condition fails.
- R4: Each dispatch presents cmd_addr = cfg_base + head*ENTRY_BYTES. Head then advances by one and wraps from QDEPTH-1 to 0.
- R5: The free-slot count drops by one per accepted dispatch and rises by one per slot_release pulse. It never exceeds SLOTS, and a release at SLOTS is ignored.
- R6: With cfg_shadow_addr nonzero, every pass begins with a DMA read (dma_we=0) at cfg_shadow_addr. The read data becomes the tail before any dispatch decision is made.
- R7: With cfg_shadow_addr nonzero, each accepted dispatch is followed by a DMA write (dma_we=1) of the current tail to cfg_evidx_addr, and then by a fresh DMA read of the shadow tail. The order per command is dispatch, write, read.
- R8: With cfg_shadow_addr nonzero, db_tail never changes the tail, but db_wr still schedules a pass.
- R9: With cfg_shadow_addr zero, db_wr loads db_tail into the tail and the block raises no DMA request.
- R10: dma_req and cmd_req stay high, with their address, write flag and write data unchanged, until the matching acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Queue base address in host memory |
| cfg_shadow_addr | input | ADDR_W | Shadow tail word address; zero disables shadow mode |
| cfg_evidx_addr | input | ADDR_W | Event-index word address |
| db_wr | input | 1 | Doorbell register write strobe |
| db_tail | input | PTR_W | Tail value carried by the doorbell write |
| slot_release | input | 1 | One request slot returned |
| dma_req | output | 1 | DMA request |
| dma_we | output | 1 | DMA direction: 1 write, 0 read |
| dma_addr | output | ADDR_W | DMA word address |
| dma_wdata | output | PTR_W | DMA write data (tail) |
| dma_ack | input | 1 | DMA acknowledge; read data valid with it |
| dma_rdata | input | PTR_W | DMA read data |
| cmd_req | output | 1 | Command fetch dispatch request |
| cmd_addr | output | ADDR_W | Address of the entry to fetch |
| cmd_ack | input | 1 | Dispatch accepted; one slot consumed |
| head | output | PTR_W | Head index |
| tail | output | PTR_W | Tail index |
| free_slots | output | SLOT_W | Free request slots |
| busy | output | 1 | A processing pass is running |

## Verification
The hardest case to reach is a host that moves the shadow tail while a pass is running. The block must then pick up the new value at its next re-read and keep going without any further doorbell. The bench's memory model raises the shadow word at the moment it acknowledges a chosen event-index write. The fetch log then shows commands beyond the tail seen at the start of the pass, and event-index values that step from the old tail to the new one. Slot exhaustion and head wrap are reached by leaving slots unreleased and walking the head across the queue end in register mode.

// File: rtl/sq_shadow_fetch.sv
module sq_shadow_fetch #(
  parameter int ADDR_W      = 32,
  parameter int PTR_W       = 16,
  parameter int QDEPTH      = 8,
  parameter int ENTRY_BYTES = 64,
  parameter int SLOTS       = 4,
  parameter int DELAY_CYC   = 25,
  parameter int SLOT_W      = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_shadow_addr,
  input  logic [ADDR_W-1:0] cfg_evidx_addr,
  input  logic              db_wr,
  input  logic [PTR_W-1:0]  db_tail,
  input  logic              slot_release,
  output logic              dma_req,
  output logic              dma_we,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [PTR_W-1:0]  dma_wdata,
  input  logic              dma_ack,
  input  logic [PTR_W-1:0]  dma_rdata,
  output logic              cmd_req,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_ack,
  output logic [PTR_W-1:0]  head,
  output logic [PTR_W-1:0]  tail,
  output logic [SLOT_W-1:0] free_slots,
  output logic              busy
);
  localparam int DLY_W = $clog2(DELAY_CYC + 1);
  localparam logic [PTR_W-1:0]  LAST_IDX = PTR_W'(QDEPTH - 1);
  localparam logic [SLOT_W-1:0] MAX_FREE = SLOT_W'(SLOTS);
  localparam logic [DLY_W-1:0]  DLY_LOAD = DLY_W'(DELAY_CYC);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_RD_TAIL, ST_CHECK, ST_DISPATCH, ST_WR_EVIDX
  } state_t;

  state_t           state;
  logic [DLY_W-1:0] dly_cnt;
  logic             armed;

  logic shadow_on, can_fetch, took_cmd, took_dma, gave_slot;
  logic [PTR_W-1:0] head_nxt;

  assign shadow_on = cfg_shadow_addr != '0;
  assign can_fetch = (head != tail) && (free_slots != '0);
  assign took_cmd  = (state == ST_DISPATCH) && cmd_ack;
  assign took_dma  = dma_req && dma_ack;
  assign gave_slot = slot_release && (free_slots != MAX_FREE);
  assign head_nxt  = (head == LAST_IDX) ? '0 : head + 1'b1;

  assign dma_req   = (state == ST_RD_TAIL) || (state == ST_WR_EVIDX);
  assign dma_we    = state == ST_WR_EVIDX;
  assign dma_addr  = dma_we ? cfg_evidx_addr : cfg_shadow_addr;
  assign dma_wdata = tail;
  assign cmd_req   = state == ST_DISPATCH;
  assign cmd_addr  = cfg_base + ADDR_W'(head) * ADDR_W'(ENTRY_BYTES);
  assign busy      = state != ST_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_cnt <= '0;
      armed   <= 1'b0;
    end else if (db_wr) begin
      dly_cnt <= DLY_LOAD;
      armed   <= 1'b1;
    end else begin
      if (dly_cnt != '0) dly_cnt <= dly_cnt - 1'b1;
      if (state == ST_IDLE && armed && dly_cnt == '0) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:
          if (armed && dly_cnt == '0 && !db_wr) state <= ST_START;
        ST_START:
          state <= shadow_on ? ST_RD_TAIL : ST_CHECK;
        ST_RD_TAIL:
          if (dma_ack) state <= ST_CHECK;
        ST_CHECK:
          state <= can_fetch ? ST_DISPATCH : ST_IDLE;
        ST_DISPATCH:
          if (cmd_ack) state <= shadow_on ? ST_WR_EVIDX : ST_CHECK;
        ST_WR_EVIDX:
          if (dma_ack) state <= ST_RD_TAIL;
        default:
          state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail <= '0;
    end else if (db_wr && !shadow_on) begin
      tail <= db_tail;
    end else if (took_dma && !dma_we) begin
      tail <= dma_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) head <= '0;
    else if (took_cmd) head <= head_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_slots <= MAX_FREE;
    else if (took_cmd && !gave_slot) free_slots <= free_slots - 1'b1;
    else if (gave_slot && !took_cmd) free_slots <= free_slots + 1'b1;
  end
endmodule

module sq_shadow_fetch_chk #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 16,
  parameter int QDEPTH = 8,
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_shadow_addr,
  input logic [ADDR_W-1:0] cfg_evidx_addr,
  input logic              dma_req,
  input logic              dma_we,
  input logic [ADDR_W-1:0] dma_addr,
  input logic [PTR_W-1:0]  dma_wdata,
  input logic              dma_ack,
  input logic              cmd_req,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_ack,
  input logic [PTR_W-1:0]  head,
  input logic [PTR_W-1:0]  tail,
  input logic [SLOT_W-1:0] free_slots
);
  p_dma_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack |=> dma_req && $stable(dma_addr) && $stable(dma_we) && $stable(dma_wdata));

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_addr));

  p_free_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    free_slots <= SLOT_W'(SLOTS));

  p_cmd_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> free_slots != '0);

  p_head_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    head < PTR_W'(QDEPTH));

  p_head_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req && cmd_ack |=> head == (($past(head) == PTR_W'(QDEPTH - 1)) ? '0 : $past(head) + 1'b1));

  p_no_dma_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shadow_addr == '0 |-> !dma_req);

  p_tail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_shadow_addr != '0 && !(dma_req && dma_ack && !dma_we) |=> $stable(tail));

  p_evidx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_we |-> dma_addr == cfg_evidx_addr && dma_wdata == tail);
endmodule

bind sq_shadow_fetch sq_shadow_fetch_chk #(
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .QDEPTH(QDEPTH), .SLOTS(SLOTS), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_shadow_addr(cfg_shadow_addr),
  .cfg_evidx_addr(cfg_evidx_addr), .dma_req(dma_req), .dma_we(dma_we),
  .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_ack(dma_ack),
  .cmd_req(cmd_req), .cmd_addr(cmd_addr), .cmd_ack(cmd_ack),
  .head(head), .tail(tail), .free_slots(free_slots)
);

// File: tb/sq_shadow_fetch_bench.sv
module sq_shadow_fetch_bench;
  localparam int ADDR_W = 32, PTR_W = 16, QDEPTH = 8, EB = 64, SLOTS = 4, DLY = 25;
  localparam int SLOT_W = $clog2(SLOTS + 1);
  localparam logic [31:0] BASE = 32'h1000_0000, SHA = 32'h0002_0010, EVA = 32'h0003_0010;

  logic clk = 0, rst_n = 0;
  logic [ADDR_W-1:0] cfg_base = BASE, cfg_shadow_addr = '0, cfg_evidx_addr = '0;
  logic db_wr = 0, slot_release = 0, dma_ack = 0, cmd_ack = 0;
  logic [PTR_W-1:0] db_tail = '0, dma_rdata = '0;
  logic dma_req, dma_we, cmd_req, busy;
  logic [ADDR_W-1:0] dma_addr, cmd_addr;
  logic [PTR_W-1:0] dma_wdata, head, tail;
  logic [SLOT_W-1:0] free_slots;

  always #10 clk = ~clk;

  sq_shadow_fetch #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .QDEPTH(QDEPTH), .ENTRY_BYTES(EB),
                    .SLOTS(SLOTS), .DELAY_CYC(DLY)) u_sq_shadow_fetch (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_shadow_addr(cfg_shadow_addr),
    .cfg_evidx_addr(cfg_evidx_addr), .db_wr(db_wr), .db_tail(db_tail),
    .slot_release(slot_release), .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_ack(dma_ack), .dma_rdata(dma_rdata), .cmd_req(cmd_req),
    .cmd_addr(cmd_addr), .cmd_ack(cmd_ack), .head(head), .tail(tail),
    .free_slots(free_slots), .busy(busy));

  int n_chk = 0, n_bad = 0;
  logic [PTR_W-1:0] sh_tail = '0, bump_val = '0;
  int bump_at = 0;
  logic [31:0] cmd_log [0:63];
  logic [PTR_W-1:0] ev_log [0:63];
  byte op_log [0:63];
  int cmd_n = 0, ev_n = 0, rd_n = 0, op_n = 0, bad_addr = 0;

  always @(negedge clk) begin
    if (dma_req && !dma_ack) begin
      dma_ack <= 1;
      if (dma_we) begin
        if (dma_addr != EVA) bad_addr <= bad_addr + 1;
        ev_log[ev_n[5:0]] = dma_wdata;
        ev_n = ev_n + 1;
        op_log[op_n[5:0]] = "W"; op_n = op_n + 1;
        if (ev_n == bump_at) sh_tail = bump_val;
      end else begin
        if (dma_addr != SHA) bad_addr <= bad_addr + 1;
        dma_rdata <= sh_tail;
        rd_n = rd_n + 1;
        op_log[op_n[5:0]] = "R"; op_n = op_n + 1;
      end
    end else dma_ack <= 0;
  end

  always @(negedge clk) begin
    if (cmd_req && !cmd_ack) begin
      cmd_ack <= 1;
      cmd_log[cmd_n[5:0]] = cmd_addr;
      cmd_n = cmd_n + 1;
      op_log[op_n[5:0]] = "C"; op_n = op_n + 1;
    end else cmd_ack <= 0;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    cmd_n = 0; ev_n = 0; rd_n = 0; op_n = 0; bad_addr = 0; bump_at = 0;
  endtask

  task automatic ring(input logic [PTR_W-1:0] v);
    @(negedge clk); db_wr = 1; db_tail = v;
    @(negedge clk); db_wr = 0;
  endtask

  task automatic wait_pass(output int lat);
    lat = 1;
    while (!busy && lat < 200) begin @(negedge clk); lat++; end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic refill();
    while (free_slots != SLOT_W'(SLOTS)) begin
      @(negedge clk); slot_release = 1;
      @(negedge clk); slot_release = 0;
    end
  endtask

  task automatic t_reset();
    check(head == 0 && tail == 0, "R1 head/tail", head, 0);
    check(free_slots == SLOTS, "R1 free", free_slots, SLOTS);
    check(!busy && !dma_req && !cmd_req, "R1 idle", {busy, dma_req, cmd_req}, 0);
  endtask

  task automatic t_register_mode();
    int lat;
    bit quiet = 1;
    clear_logs();
    @(negedge clk); db_wr = 1; db_tail = 3;
    @(negedge clk); db_wr = 0;
    for (int i = 0; i < DLY - 2; i++) begin
      if (busy || dma_req || cmd_req) quiet = 0;
      @(negedge clk);
    end
    check(quiet, "R2 no early start", quiet, 1);
    lat = DLY - 1;
    while (!busy && lat < 200) begin @(negedge clk); lat++; end
    check(lat >= DLY && lat <= DLY + 3, "R2 start latency", lat, DLY + 2);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(cmd_n == 3, "R3 three fetched", cmd_n, 3);
    check(cmd_log[0] == BASE && cmd_log[1] == BASE + 64 && cmd_log[2] == BASE + 128,
          "R4 fetch addresses", cmd_log[2], BASE + 128);
    check(rd_n + ev_n == 0, "R9 no DMA", rd_n + ev_n, 0);
    check(tail == 3 && head == 3, "R9 register tail", tail, 3);
    check(free_slots == 1, "R5 slots used", free_slots, 1);
  endtask

  task automatic t_slot_limit();
    int lat;
    clear_logs();
    ring(7); wait_pass(lat);
    check(cmd_n == 1 && cmd_log[0] == BASE + 192, "R3 stop on slots", cmd_n, 1);
    check(head == 4 && free_slots == 0, "R3 head at stop", head, 4);
    refill();
    @(negedge clk); slot_release = 1;
    @(negedge clk); slot_release = 0;
    check(free_slots == SLOTS, "R5 release at max ignored", free_slots, SLOTS);
    clear_logs();
    ring(7); wait_pass(lat);
    check(cmd_n == 3 && head == 7 && free_slots == 1, "R3 resume", cmd_n, 3);
  endtask

  task automatic t_wrap();
    int lat;
    refill(); clear_logs();
    ring(2); wait_pass(lat);
    check(cmd_n == 3, "R4 wrap count", cmd_n, 3);
    check(cmd_log[0] == BASE + 7 * EB && cmd_log[1] == BASE && cmd_log[2] == BASE + EB,
          "R4 wrap addresses", cmd_log[1], BASE);
    check(head == 2, "R4 wrap head", head, 2);
  endtask

  task automatic t_shadow();
    int lat;
    string seq = "";
    refill(); clear_logs();
    cfg_shadow_addr = SHA; cfg_evidx_addr = EVA; sh_tail = 4;
    ring(6);
    check(tail == 2, "R8 register tail ignored", tail, 2);
    wait_pass(lat);
    check(rd_n == 3 && ev_n == 2 && cmd_n == 2, "R6 read count", rd_n, 3);
    for (int i = 0; i < op_n; i++) seq = {seq, string'(op_log[i])};
    check(seq == "RCWRCWR", "R7 order", op_n, 7);
    check(ev_log[0] == 4 && ev_log[1] == 4, "R7 event value", ev_log[1], 4);
    check(bad_addr == 0, "R6 R7 DMA addresses", bad_addr, 0);
    check(head == 4 && tail == 4, "R8 tail from shadow", tail, 4);
  endtask

  task automatic t_bump();
    int lat;
    refill(); clear_logs();
    sh_tail = 5; bump_at = 1; bump_val = 7;
    ring(0); wait_pass(lat);
    check(cmd_n == 3 && head == 7 && tail == 7, "R7 re-read extends pass", cmd_n, 3);
    check(ev_log[0] == 5 && ev_log[1] == 7 && ev_log[2] == 7, "R7 event values",
          ev_log[1], 7);
    check(rd_n == 4, "R6 R7 read count", rd_n, 4);
  endtask

  task automatic t_empty();
    int lat;
    refill(); clear_logs();
    ring(3); wait_pass(lat);
    check(rd_n == 1 && cmd_n == 0 && ev_n == 0, "R3 R6 empty queue", cmd_n, 0);
    check(tail == 7, "R8 empty tail", tail, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    fork
      begin
        t_reset(); t_register_mode(); t_slot_limit(); t_wrap();
        t_shadow(); t_bump(); t_empty();
      end
      begin
        repeat (100000) @(negedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule